// File: doc/BRIEF.md
# Lockable Pin Function Multiplexer

This block decides, for each pin of a small pad bank (eight by default), whether the pad is driven by the general-purpose I/O output and direction or by one of the on-chip peripheral functions. Each pin has four pieces of configuration: a route-enable bit, a function-select field, a pull bit and a drive-strength bit. All four are held in registers on a simple write/read bus. The selected function's output and output-enable go to every pin routed to it. The function's input is gathered from those same pins. An active-high input is the OR of the routed pins, and an active-low input is the AND.

A two-bit guard register can freeze the pin configuration, and it can also freeze itself until the next reset. A write that the guard refuses leaves the register unchanged and raises a one-cycle error pulse. The block also handles a change of function safely. When a pin is newly routed, or moved to a different function, it stays under general-purpose control for a set number of cycles, so the old and the new function never drive the pad together.

Top module: `pinmux_lock`

## Requirements
- R1: After reset the enable, select, pull, drive and guard registers all read 0, `bus_err` is low, and every pad follows `gpio_out`/`gpio_oe`.
- R2: A pin that is not actively routed has `pad_out` equal to `gpio_out` and `pad_oe` equal to `gpio_oe` for that pin.
- R3: An actively routed pin whose select bit is s (register address 1, bit i for pin i) drives `pad_out`=`fn_out[s]` and `pad_oe`=`fn_oe[s]`. The enable register is at address 0, bit i for pin i.
- R4: When several pins are routed to the same function, all of them carry that function's output at the same time.
- R5: `fn_in[0]` (active-high) is the OR of the pads actively routed to function 0, and 0 when there are none. `fn_in[1]` (active-low) is the AND of the pads actively routed to function 1, and 1 when there are none. A pin still in its switch-over gap does not contribute.
- R6: A write that enables a pin, or that changes the select bit of an enabled pin, keeps that pin under GPIO control for GAP (default 2) cycles after the write edge. Clearing the enable bit takes effect at once.
- R7: Guard codes (address 4, bits 1:0) 01 and 11 block writes to addresses 0 to 3. Codes 00 and 10 allow those writes.
- R8: Once the guard holds 10 or 11, writes to the guard are ignored. Only reset returns it to 00.
- R9: A refused write, whether to addresses 0 to 3 or to a locked guard, raises `bus_err` for exactly the cycle after the write edge. Accepted writes never raise it.
- R10: Every register reads back its value on `bus_rdata` whatever the guard state.
- R11: The pull register (address 2) and the drive register (address 3) appear bit for bit on `pad_pull` and `pad_drive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr (combinational) |
| bus_err | output | 1 | One-cycle pulse after a refused write |
| gpio_out | input | NPINS | GPIO output value per pin |
| gpio_oe | input | NPINS | GPIO output enable per pin |
| fn_out | input | NFUNC | Output of each peripheral function |
| fn_oe | input | NFUNC | Output enable of each peripheral function |
| fn_in | output | NFUNC | Gathered input to each peripheral function |
| pad_in | input | NPINS | Level seen at each pad |
| pad_out | output | NPINS | Value driven to each pad |
| pad_oe | output | NPINS | Output enable of each pad |
| pad_pull | output | NPINS | Pull control of each pad |
| pad_drive | output | NPINS | Drive-strength control of each pad |

## Verification
The hardest state to reach from the ports is the short gap after a route change. For two cycles the enable register already reads 1, yet the pad and the gathered input still behave as GPIO. The stimulus holds `fn_oe` and `gpio_oe` at opposite levels and drives a pad level that would change `fn_in`. The pin's owner is then sampled on each of the cycles right after a write that enables the pin, and again after a write that moves it to the other function. The locked guard states also need a reset in the middle of the run, because nothing else can reach the 10 code a second time.

// File: rtl/pinmux_lock_pkg.sv
package pinmux_lock_pkg;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    REG_EN    = 3'd0,
    REG_SEL   = 3'd1,
    REG_PULL  = 3'd2,
    REG_DRIVE = 3'd3,
    REG_GUARD = 3'd4
  } reg_addr_e;

  // guard codes: bit 0 freezes the pin registers, bit 1 freezes the guard itself
  typedef enum logic [1:0] {
    GUARD_OPEN        = 2'b00,
    GUARD_SHUT        = 2'b01,
    GUARD_OPEN_STICKY = 2'b10,
    GUARD_SHUT_STICKY = 2'b11
  } guard_e;

  function automatic logic cfg_frozen(logic [1:0] g);
    return g[0];
  endfunction

  function automatic logic guard_frozen(logic [1:0] g);
    return g[1];
  endfunction

  // a pin needs a break when it becomes routed or changes function while routed
  function automatic logic needs_break(logic old_en, logic new_en, logic sel_moved);
    return new_en && (!old_en || sel_moved);
  endfunction

  // combine the pads that claim a function input
  function automatic logic gather(logic [63:0] pins, logic [63:0] claim, logic act_low);
    return act_low ? &(pins | ~claim) : |(pins & claim);
  endfunction
endpackage

// File: rtl/pinmux_lock_regs.sv
module pinmux_lock_regs
  import pinmux_lock_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int SELW  = 1,
  parameter int DW    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [AW-1:0]         bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  output logic [NPINS-1:0]      en_q,
  output logic [NPINS-1:0]      en_nxt,
  output logic [NPINS*SELW-1:0] sel_q,
  output logic [NPINS*SELW-1:0] sel_nxt,
  output logic [NPINS-1:0]      pull_q,
  output logic [NPINS-1:0]      drive_q,
  output logic [1:0]            guard_q,
  output logic                  wr_err
);
  localparam int SW = NPINS * SELW;

  logic hit_en, hit_sel, hit_pull, hit_drive, hit_guard;
  logic cfg_ok, cfg_refused, guard_refused;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata;

  always_comb begin
    hit_en        = bus_wr && (bus_addr == REG_EN);
    hit_sel       = bus_wr && (bus_addr == REG_SEL);
    hit_pull      = bus_wr && (bus_addr == REG_PULL);
    hit_drive     = bus_wr && (bus_addr == REG_DRIVE);
    hit_guard     = bus_wr && (bus_addr == REG_GUARD);
    cfg_ok        = !cfg_frozen(guard_q);
    cfg_refused   = (hit_en || hit_sel || hit_pull || hit_drive) && !cfg_ok;
    guard_refused = hit_guard && guard_frozen(guard_q);
    en_nxt        = (hit_en && cfg_ok) ? bus_wdata[NPINS-1:0] : en_q;
    sel_nxt       = (hit_sel && cfg_ok) ? bus_wdata[SW-1:0] : sel_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      sel_q   <= '0;
      pull_q  <= '0;
      drive_q <= '0;
      guard_q <= GUARD_OPEN;
      wr_err  <= 1'b0;
    end else begin
      en_q  <= en_nxt;
      sel_q <= sel_nxt;
      if (hit_pull && cfg_ok)          pull_q  <= bus_wdata[NPINS-1:0];
      if (hit_drive && cfg_ok)         drive_q <= bus_wdata[NPINS-1:0];
      if (hit_guard && !guard_refused) guard_q <= bus_wdata[1:0];
      wr_err <= cfg_refused || guard_refused;
    end
  end

  // readback ignores the guard state
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_EN:    bus_rdata[NPINS-1:0] = en_q;
      REG_SEL:   bus_rdata[SW-1:0]    = sel_q;
      REG_PULL:  bus_rdata[NPINS-1:0] = pull_q;
      REG_DRIVE: bus_rdata[NPINS-1:0] = drive_q;
      REG_GUARD: bus_rdata[1:0]       = guard_q;
      default:   bus_rdata = '0;
    endcase
  end

  assert_guard_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    guard_q[1] |=> (guard_q == $past(guard_q)));

  assert_refused_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == REG_EN || bus_addr == REG_SEL) && guard_q[0])
      |=> ($stable(en_q) && $stable(sel_q)));

  assert_err_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(bus_wr));
endmodule

// File: rtl/pinmux_lock_gap.sv
module pinmux_lock_gap
  import pinmux_lock_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int SELW  = 1,
  parameter int GAP   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPINS-1:0]      en_q,
  input  logic [NPINS-1:0]      en_nxt,
  input  logic [NPINS*SELW-1:0] sel_q,
  input  logic [NPINS*SELW-1:0] sel_nxt,
  output logic [NPINS-1:0]      route_act,
  output logic [NPINS-1:0]      break_evt
);
  localparam int CW = (GAP > 0) ? $clog2(GAP + 1) : 1;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [CW-1:0] wait_cnt;
    logic          sel_moved;

    assign sel_moved    = sel_nxt[i*SELW +: SELW] != sel_q[i*SELW +: SELW];
    assign break_evt[i] = needs_break(en_q[i], en_nxt[i], sel_moved);

    always_ff @(posedge clk) begin
      if (!rst_n)                wait_cnt <= '0;
      else if (!en_nxt[i])       wait_cnt <= '0;
      else if (break_evt[i])     wait_cnt <= CW'(GAP);
      else if (wait_cnt != '0)   wait_cnt <= wait_cnt - 1'b1;
    end

    assign route_act[i] = en_q[i] && (wait_cnt == '0);
  end

  if (GAP > 0) begin : g_chk
    assert_break_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|break_evt) |=> ((route_act & $past(break_evt)) == '0));
  end
endmodule

// File: rtl/pinmux_lock_route.sv
module pinmux_lock_route
  import pinmux_lock_pkg::*;
#(
  parameter int               NPINS      = 8,
  parameter int               NFUNC      = 2,
  parameter int               SELW       = 1,
  parameter logic [NFUNC-1:0] FN_ACT_LOW = 2'b10
) (
  input  logic [NPINS-1:0]       route_act,
  input  logic [NPINS*SELW-1:0]  sel_q,
  input  logic [NPINS-1:0]       gpio_out,
  input  logic [NPINS-1:0]       gpio_oe,
  input  logic [NFUNC-1:0]       fn_out,
  input  logic [NFUNC-1:0]       fn_oe,
  input  logic [NPINS-1:0]       pad_in,
  output logic [NPINS-1:0]       pad_out,
  output logic [NPINS-1:0]       pad_oe,
  output logic [NFUNC-1:0]       fn_in,
  output logic [NFUNC*NPINS-1:0] fn_claim
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [SELW-1:0] pick;
    logic            pick_ok;
    assign pick    = sel_q[i*SELW +: SELW];
    assign pick_ok = int'(pick) < NFUNC;
    assign pad_out[i] = route_act[i] ? (pick_ok && fn_out[pick]) : gpio_out[i];
    assign pad_oe[i]  = route_act[i] ? (pick_ok && fn_oe[pick])  : gpio_oe[i];
    for (genvar f = 0; f < NFUNC; f++) begin : g_fn
      assign fn_claim[f*NPINS + i] = route_act[i] && (pick == SELW'(f));
    end
  end

  for (genvar f = 0; f < NFUNC; f++) begin : g_gather
    assign fn_in[f] = gather(64'(pad_in), 64'(fn_claim[f*NPINS +: NPINS]), FN_ACT_LOW[f]);
  end
endmodule

// File: rtl/pinmux_lock.sv
module pinmux_lock
  import pinmux_lock_pkg::*;
#(
  parameter int               NPINS      = 8,
  parameter int               NFUNC      = 2,
  parameter int               DW         = 16,
  parameter int               GAP        = 2,
  parameter logic [NFUNC-1:0] FN_ACT_LOW = 2'b10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             bus_err,
  input  logic [NPINS-1:0] gpio_out,
  input  logic [NPINS-1:0] gpio_oe,
  input  logic [NFUNC-1:0] fn_out,
  input  logic [NFUNC-1:0] fn_oe,
  output logic [NFUNC-1:0] fn_in,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pull,
  output logic [NPINS-1:0] pad_drive
);
  localparam int SELW = (NFUNC > 1) ? $clog2(NFUNC) : 1;
  localparam int SW   = NPINS * SELW;

  logic [NPINS-1:0]       en_q, en_nxt, route_act, break_evt;
  logic [SW-1:0]          sel_q, sel_nxt;
  logic [1:0]             guard_q;
  logic [NFUNC*NPINS-1:0] fn_claim;

  pinmux_lock_regs #(.NPINS(NPINS), .SELW(SELW), .DW(DW)) regs_i (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .en_q, .en_nxt, .sel_q, .sel_nxt,
    .pull_q(pad_pull), .drive_q(pad_drive), .guard_q, .wr_err(bus_err)
  );

  pinmux_lock_gap #(.NPINS(NPINS), .SELW(SELW), .GAP(GAP)) gap_i (
    .clk, .rst_n, .en_q, .en_nxt, .sel_q, .sel_nxt, .route_act, .break_evt
  );

  pinmux_lock_route #(.NPINS(NPINS), .NFUNC(NFUNC), .SELW(SELW),
                      .FN_ACT_LOW(FN_ACT_LOW)) route_i (
    .route_act, .sel_q, .gpio_out, .gpio_oe, .fn_out, .fn_oe, .pad_in,
    .pad_out, .pad_oe, .fn_in, .fn_claim
  );

  assert_gpio_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_oe ^ gpio_oe) | (pad_out ^ gpio_out)) & ~route_act) == '0);

  for (genvar f = 0; f < NFUNC; f++) begin : g_idle_chk
    assert_idle_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_claim[f*NPINS +: NPINS] == '0) |-> (fn_in[f] == FN_ACT_LOW[f]));
  end
endmodule

// File: tb/pinmux_lock_tb_top.sv
module pinmux_lock_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_err;
  logic [7:0]  gpio_out = '0, gpio_oe = '0, pad_in = '0;
  logic [1:0]  fn_out = '0, fn_oe = '0, fn_in;
  logic [7:0]  pad_out, pad_oe, pad_pull, pad_drive;

  int checks = 0;
  int errors = 0;
  logic [15:0] rv;

  always #2 clk = ~clk;

  pinmux_lock dut_i (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .bus_err,
    .gpio_out, .gpio_oe, .fn_out, .fn_oe, .fn_in, .pad_in,
    .pad_out, .pad_oe, .pad_pull, .pad_drive
  );

  // en, sel, gpio_out, fn_out, pad_in, expected pad_out, expected fn_in
  localparam logic [43:0] VEC [5] = '{
    {8'h00, 8'h00, 8'hA5, 2'b11, 8'hFF, 8'hA5, 2'b10},
    {8'hFF, 8'h00, 8'h00, 2'b01, 8'h01, 8'hFF, 2'b11},
    {8'hFF, 8'hFF, 8'h00, 2'b01, 8'hFE, 8'h00, 2'b00},
    {8'hF0, 8'hC0, 8'h05, 2'b10, 8'h7F, 8'hC5, 2'b01},
    {8'h3C, 8'h0C, 8'h81, 2'b10, 8'h0C, 8'h8D, 2'b10}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    gpio_out = 8'h5A; gpio_oe = 8'h3C;
    do_reset();
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), rv);
      chk("R1 reg reads zero", rv, 0);
    end
    chk("R1 pad_out follows gpio", pad_out, 8'h5A);
    chk("R1 pad_oe follows gpio", pad_oe, 8'h3C);
    chk("R1 bus_err low", bus_err, 0);
    chk("R1 idle fn_in", fn_in, 2'b10);

    // table: R2 R3 R4 R5
    fn_oe = 2'b11; gpio_oe = 8'h0F;
    for (int v = 0; v < 5; v++) begin
      wr(3'd0, {8'h00, VEC[v][43:36]});
      wr(3'd1, {8'h00, VEC[v][35:28]});
      gpio_out = VEC[v][27:20];
      fn_out   = VEC[v][19:18];
      pad_in   = VEC[v][17:10];
      repeat (3) @(negedge clk);
      #1;
      chk("R3 R4 R2 pad_out", pad_out, VEC[v][9:2]);
      chk("R3 R2 pad_oe", pad_oe, VEC[v][43:36] | (8'h0F & ~VEC[v][43:36]));
      chk("R5 fn_in gather", fn_in, VEC[v][1:0]);
    end

    // R6 break before make
    wr(3'd0, 16'h0); wr(3'd1, 16'h0);
    gpio_oe = 8'h00; fn_oe = 2'b11; gpio_out = 8'h00; fn_out = 2'b01; pad_in = 8'h01;
    wr(3'd0, 16'h01);
    chk("R6 gap cycle 1 oe", pad_oe[0], 0);
    chk("R5 gap pin not gathered", fn_in[0], 0);
    @(negedge clk); #1;
    chk("R6 gap cycle 2 oe", pad_oe[0], 0);
    @(negedge clk); #1;
    chk("R6 routed after gap", pad_oe[0], 1);
    chk("R5 routed pin gathered", fn_in[0], 1);
    wr(3'd1, 16'h01);
    chk("R6 reselect gap 1", pad_oe[0], 0);
    @(negedge clk); #1;
    chk("R6 reselect gap 2", pad_oe[0], 0);
    @(negedge clk); #1;
    chk("R6 reselect routed", pad_oe[0], 1);
    chk("R3 func1 output", pad_out[0], 0);
    fn_oe = 2'b00; gpio_oe = 8'hFF; #1;
    chk("R3 func1 oe", pad_oe[0], 0);
    wr(3'd0, 16'h00);
    chk("R6 disable immediate", pad_oe[0], 1);

    // R7 R9 R10 guard
    wr(3'd4, 16'h1);
    chk("R9 guard write accepted", bus_err, 0);
    wr(3'd0, 16'hFF);
    chk("R9 refused write pulse", bus_err, 1);
    rd(3'd0, rv);
    chk("R7 enable unchanged", rv, 16'h00);
    rd(3'd4, rv);
    chk("R10 guard readable", rv, 16'h1);
    @(negedge clk); #1;
    chk("R9 pulse one cycle", bus_err, 0);
    wr(3'd1, 16'hFF);
    rd(3'd1, rv);
    chk("R7 select unchanged", rv, 16'h01);
    wr(3'd2, 16'hFF);
    chk("R7 pull unchanged", pad_pull, 8'h00);
    wr(3'd4, 16'h0);
    chk("R8 unlocked guard writable", bus_err, 0);
    wr(3'd2, 16'h55);
    chk("R11 pull output", pad_pull, 8'h55);
    wr(3'd3, 16'hAA);
    chk("R11 drive output", pad_drive, 8'hAA);
    wr(3'd4, 16'h3);
    wr(3'd4, 16'h0);
    chk("R9 locked guard write pulse", bus_err, 1);
    rd(3'd4, rv);
    chk("R8 guard stays 11", rv, 16'h3);
    wr(3'd3, 16'h00);
    chk("R7 drive unchanged", pad_drive, 8'hAA);

    // R8 reset releases lock; 10 allows config but freezes guard
    do_reset();
    rd(3'd4, rv);
    chk("R1 R8 guard cleared by reset", rv, 16'h0);
    chk("R1 drive cleared", pad_drive, 8'h00);
    wr(3'd4, 16'h2);
    wr(3'd0, 16'h0F);
    chk("R7 code 10 allows write", bus_err, 0);
    rd(3'd0, rv);
    chk("R7 enable written under 10", rv, 16'h0F);
    wr(3'd4, 16'h1);
    chk("R9 sticky guard pulse", bus_err, 1);
    rd(3'd4, rv);
    chk("R8 guard stays 10", rv, 16'h2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule